// File: doc/BRIEF.md
# PCIe Root-Complex Bring-Up Sequencer

This block walks a multi-lane PCIe root-complex controller and its two PHYs from power-off to link training. It runs entirely in hardware and needs no software involvement. A single start pulse launches the walk. The block then orders the board slot reset, the controller reset, slot power, the auxiliary clock gate, the PHY hold and the power-up reset. It programs a fixed termination and enable word into every PHY lane through an external register-write engine. Finally it selects root-complex mode and enables link training.

Three timing sources pace the walk. A free-running millisecond tick sets the reset hold time after power is applied. A cycle counter sets the settle time after the PHY configuration selects are raised. A done/error handshake from the write engine advances the lane writes. A write error is remembered in a sticky flag, but the walk does not stop on it.

A shutdown request can arrive at any point. It forces both reset lines low and returns the block to idle, which brings the link down. A new start is accepted from idle or from the link-up state and repeats the whole walk.

Top module: `pcie_bringup_seq`

## Requirements
- R1: After reset, every output is low or zero. Both resets are asserted, and power, clock gate, hold, power-up release, selects, request, device type, training enable, busy and error are all off.
- R2: A start accepted in idle or link-up first drives the slot reset low, together with busy high. The controller reset goes low one cycle later, and slot power goes high one cycle after that. A start from link-up also clears the clock gate, the device type and training enable on its first cycle.
- R3: After slot power rises, the controller reset stays asserted until PERST_MS+1 millisecond ticks have been counted. This guarantees at least PERST_MS whole tick periods.
- R4: The controller reset is released first. The slot reset is released on the next cycle.
- R5: After the slot reset is released, the auxiliary clock turns on, then the PHY hold is asserted, then the active-low power-up reset is released, one cycle apart.
- R6: All PHY configuration selects rise on the cycle after the power-up release. The first write request comes at least SEL_WAIT_CYC cycles after that.
- R7: There are NUM_PHY×LANES_PER_PHY writes. They go lane by lane within a PHY, PHY 0 first. Each write targets address 0x1008 + 0x100×lane, carries data 0x0E21 (bits 0, 5, 9, 10, 11 set) and reports the PHY number on wr_phy_o. Every write happens with the PHY hold asserted and training off.
- R8: A write request holds its PHY index, address and data steady until wr_done_i is sampled high. It then drops for at least one cycle before the next write.
- R9: One cycle after the last write's done is sampled, the auxiliary clock turns off. The PHY hold clears on the next cycle, and the clock turns back on the cycle after that.
- R10: The device type then becomes 4 (root complex). One cycle later link training is enabled and busy falls in the same cycle.
- R11: wr_err_i sampled together with wr_done_i sets err_o. err_o stays set until reset, and the walk still completes.
- R12: A shutdown drives both resets low, clears training enable, the write request and busy on the next cycle, and returns to idle. No reset is released until a new start. Shutdown wins over start.
- R13: A start that arrives while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse |
| shutdown_i | input | 1 | Link-down request |
| ms_tick_i | input | 1 | One-cycle pulse every millisecond |
| wr_done_i | input | 1 | Write engine completed the current request |
| wr_err_i | input | 1 | Write engine error, valid with wr_done_i |
| slot_rst_n_o | output | 1 | Board slot reset, active low |
| ctl_rst_n_o | output | 1 | Controller reset, active low |
| slot_pwr_en_o | output | 1 | Slot power enable |
| aux_clk_en_o | output | 1 | Auxiliary clock gate enable |
| phy_hold_o | output | 1 | Hold PHY/link state machine in reset |
| pwrup_rst_n_o | output | 1 | Power-up reset, active low |
| cfg_sel_o | output | NUM_PHY | Per-PHY parallel configuration select |
| wr_req_o | output | 1 | PHY register write request |
| wr_phy_o | output | PHY_W | PHY index of the request |
| wr_addr_o | output | ADDR_W | Lane register address |
| wr_data_o | output | DATA_W | Write data |
| dev_type_o | output | DEVT_W | Device-type field |
| link_train_en_o | output | 1 | Link training enable |
| busy_o | output | 1 | Walk in progress |
| err_o | output | 1 | Sticky write error |

## Verification
The bench builds the block with PERST_MS=3 and SEL_WAIT_CYC=5 and drives a tick every four cycles. With these values the reset hold is measured in full, tick by tick, in a few dozen cycles rather than a hundred thousand. It keeps the default two PHYs of four lanes each, so all eight lane writes and the PHY 0 to PHY 1 rollover are covered. The short hold also makes several complete walks affordable in one run: a restart from link-up with an injected error and a start poked mid-write, a shutdown during the hold, and a shutdown in the middle of the lane writes.

// File: rtl/pbs_pkg.sv
package pbs_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_CTL_ASSERT,
        ST_PWR_ON,
        ST_PERST_WAIT,
        ST_SLOT_REL,
        ST_AUX_ON,
        ST_HOLD_SET,
        ST_PWRUP_REL,
        ST_SEL_SET,
        ST_SEL_WAIT,
        ST_WRITE,
        ST_WR_GAP,
        ST_AUX_OFF,
        ST_HOLD_CLR,
        ST_AUX_REON,
        ST_DEVTYPE,
        ST_LINK_EN,
        ST_LINK_UP
    } seq_state_e;

    typedef struct packed {
        logic slot_rst_n;
        logic ctl_rst_n;
        logic pwr_en;
        logic aux_en;
        logic phy_hold;
        logic pwrup_rst_n;
        logic wr_req;
        logic link_en;
        logic busy;
        logic err;
    } seq_ctrl_t;

    localparam seq_ctrl_t CTRL_RESET = '{default: 1'b0};

    // Lane word: CDR tracking, LOS threshold, termination, AC coupling, PHY enable
    localparam logic [15:0] LANE_INIT_WORD = (16'h1 << 0) | (16'h1 << 5) |
                                             (16'h1 << 9) | (16'h1 << 10) |
                                             (16'h1 << 11);
    localparam logic [15:0] LANE_REG_BASE  = 16'h1008;
    localparam logic [15:0] LANE_REG_STEP  = 16'h0100;
    localparam int unsigned DEV_TYPE_RC    = 4;

    function automatic int unsigned idx_w(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    function automatic logic [15:0] lane_reg_addr(input logic [7:0] lane);
        return LANE_REG_BASE + LANE_REG_STEP * {8'd0, lane};
    endfunction

endpackage

// File: rtl/pbs_evt_count.sv
module pbs_evt_count #(
    parameter int unsigned LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic inc,
    output logic done_o
);
    localparam int unsigned CW = (LIMIT < 1) ? 1 : $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign done_o = (cnt_q == CW'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (inc && !done_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/pbs_lane_walker.sv
module pbs_lane_walker
    import pbs_pkg::*;
#(
    parameter  int unsigned NUM_PHY = 2,
    parameter  int unsigned LANES   = 4,
    localparam int unsigned PHY_W   = idx_w(NUM_PHY),
    localparam int unsigned LANE_W  = idx_w(LANES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              step,
    output logic [PHY_W-1:0]  phy_o,
    output logic [LANE_W-1:0] lane_o,
    output logic              last_o
);
    logic lane_wrap;

    assign lane_wrap = (lane_o == LANE_W'(LANES - 1));
    assign last_o    = lane_wrap && (phy_o == PHY_W'(NUM_PHY - 1));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            phy_o  <= '0;
            lane_o <= '0;
        end else if (step && !last_o) begin
            if (lane_wrap) begin
                lane_o <= '0;
                phy_o  <= phy_o + 1'b1;
            end else begin
                lane_o <= lane_o + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pcie_bringup_seq.sv
module pcie_bringup_seq
    import pbs_pkg::*;
#(
    parameter  int unsigned NUM_PHY       = 2,
    parameter  int unsigned LANES_PER_PHY = 4,
    parameter  int unsigned PERST_MS      = 100,
    parameter  int unsigned SEL_WAIT_CYC  = 10,
    parameter  int unsigned ADDR_W        = 16,
    parameter  int unsigned DATA_W        = 16,
    parameter  int unsigned DEVT_W        = 4,
    localparam int unsigned PHY_W         = idx_w(NUM_PHY),
    localparam int unsigned LANE_W        = idx_w(LANES_PER_PHY)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              shutdown_i,
    input  logic              ms_tick_i,
    input  logic              wr_done_i,
    input  logic              wr_err_i,
    output logic              slot_rst_n_o,
    output logic              ctl_rst_n_o,
    output logic              slot_pwr_en_o,
    output logic              aux_clk_en_o,
    output logic              phy_hold_o,
    output logic              pwrup_rst_n_o,
    output logic [NUM_PHY-1:0] cfg_sel_o,
    output logic              wr_req_o,
    output logic [PHY_W-1:0]  wr_phy_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [DEVT_W-1:0] dev_type_o,
    output logic              link_train_en_o,
    output logic              busy_o,
    output logic              err_o
);
    // One extra tick covers the unknown phase of the first tick
    localparam int unsigned PERST_TICKS = PERST_MS + 1;

    seq_state_e         state_q;
    seq_ctrl_t          ctl_q;
    logic [NUM_PHY-1:0] sel_q;
    logic [DEVT_W-1:0]  devt_q;

    logic perst_clr, perst_inc, perst_done;
    logic settle_clr, settle_inc, settle_done;
    logic walk_clr, walk_step, walk_last;
    logic [LANE_W-1:0] lane_idx;
    logic start_ok;

    assign perst_clr  = (state_q == ST_PWR_ON);
    assign perst_inc  = (state_q == ST_PERST_WAIT) && ms_tick_i;
    assign settle_clr = (state_q == ST_SEL_SET);
    assign settle_inc = (state_q == ST_SEL_WAIT);
    assign walk_clr   = (state_q == ST_SEL_SET);
    assign walk_step  = (state_q == ST_WRITE) && wr_done_i && !shutdown_i;
    assign start_ok   = start_i && ((state_q == ST_IDLE) || (state_q == ST_LINK_UP));

    pbs_evt_count #(.LIMIT(PERST_TICKS)) u_perst_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (perst_clr),
        .inc    (perst_inc),
        .done_o (perst_done)
    );

    pbs_evt_count #(.LIMIT(SEL_WAIT_CYC)) u_settle_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (settle_clr),
        .inc    (settle_inc),
        .done_o (settle_done)
    );

    pbs_lane_walker #(.NUM_PHY(NUM_PHY), .LANES(LANES_PER_PHY)) u_walker (
        .clk    (clk),
        .rst    (rst),
        .clr    (walk_clr),
        .step   (walk_step),
        .phy_o  (wr_phy_o),
        .lane_o (lane_idx),
        .last_o (walk_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctl_q   <= CTRL_RESET;
            sel_q   <= '0;
            devt_q  <= '0;
        end else if (shutdown_i) begin
            ctl_q.slot_rst_n <= 1'b0;
            ctl_q.ctl_rst_n  <= 1'b0;
            ctl_q.link_en    <= 1'b0;
            ctl_q.wr_req     <= 1'b0;
            ctl_q.busy       <= 1'b0;
            state_q          <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_LINK_UP: begin
                    if (start_ok) begin
                        ctl_q.slot_rst_n  <= 1'b0;
                        ctl_q.busy        <= 1'b1;
                        ctl_q.aux_en      <= 1'b0;
                        ctl_q.phy_hold    <= 1'b0;
                        ctl_q.pwrup_rst_n <= 1'b0;
                        ctl_q.wr_req      <= 1'b0;
                        ctl_q.link_en     <= 1'b0;
                        sel_q             <= '0;
                        devt_q            <= '0;
                        state_q           <= ST_CTL_ASSERT;
                    end
                end
                ST_CTL_ASSERT: begin
                    ctl_q.ctl_rst_n <= 1'b0;
                    state_q         <= ST_PWR_ON;
                end
                ST_PWR_ON: begin
                    ctl_q.pwr_en <= 1'b1;
                    state_q      <= ST_PERST_WAIT;
                end
                ST_PERST_WAIT: begin
                    if (perst_done) begin
                        ctl_q.ctl_rst_n <= 1'b1;
                        state_q         <= ST_SLOT_REL;
                    end
                end
                ST_SLOT_REL: begin
                    ctl_q.slot_rst_n <= 1'b1;
                    state_q          <= ST_AUX_ON;
                end
                ST_AUX_ON: begin
                    ctl_q.aux_en <= 1'b1;
                    state_q      <= ST_HOLD_SET;
                end
                ST_HOLD_SET: begin
                    ctl_q.phy_hold <= 1'b1;
                    state_q        <= ST_PWRUP_REL;
                end
                ST_PWRUP_REL: begin
                    ctl_q.pwrup_rst_n <= 1'b1;
                    state_q           <= ST_SEL_SET;
                end
                ST_SEL_SET: begin
                    sel_q   <= '1;
                    state_q <= ST_SEL_WAIT;
                end
                ST_SEL_WAIT: begin
                    if (settle_done) begin
                        ctl_q.wr_req <= 1'b1;
                        state_q      <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (wr_done_i) begin
                        ctl_q.wr_req <= 1'b0;
                        ctl_q.err    <= ctl_q.err | wr_err_i;
                        state_q      <= walk_last ? ST_AUX_OFF : ST_WR_GAP;
                    end
                end
                ST_WR_GAP: begin
                    ctl_q.wr_req <= 1'b1;
                    state_q      <= ST_WRITE;
                end
                ST_AUX_OFF: begin
                    ctl_q.aux_en <= 1'b0;
                    state_q      <= ST_HOLD_CLR;
                end
                ST_HOLD_CLR: begin
                    ctl_q.phy_hold <= 1'b0;
                    state_q        <= ST_AUX_REON;
                end
                ST_AUX_REON: begin
                    ctl_q.aux_en <= 1'b1;
                    state_q      <= ST_DEVTYPE;
                end
                ST_DEVTYPE: begin
                    devt_q  <= DEVT_W'(DEV_TYPE_RC);
                    state_q <= ST_LINK_EN;
                end
                ST_LINK_EN: begin
                    ctl_q.link_en <= 1'b1;
                    ctl_q.busy    <= 1'b0;
                    state_q       <= ST_LINK_UP;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign slot_rst_n_o    = ctl_q.slot_rst_n;
    assign ctl_rst_n_o     = ctl_q.ctl_rst_n;
    assign slot_pwr_en_o   = ctl_q.pwr_en;
    assign aux_clk_en_o    = ctl_q.aux_en;
    assign phy_hold_o      = ctl_q.phy_hold;
    assign pwrup_rst_n_o   = ctl_q.pwrup_rst_n;
    assign cfg_sel_o       = sel_q;
    assign wr_req_o        = ctl_q.wr_req;
    assign wr_addr_o       = ADDR_W'(lane_reg_addr(8'(lane_idx)));
    assign wr_data_o       = DATA_W'(LANE_INIT_WORD);
    assign dev_type_o      = devt_q;
    assign link_train_en_o = ctl_q.link_en;
    assign busy_o          = ctl_q.busy;
    assign err_o           = ctl_q.err;

endmodule

// File: rtl/pbs_seq_chk.sv
module pbs_seq_chk #(
    parameter int unsigned NUM_PHY = 2,
    parameter int unsigned PHY_W   = 1,
    parameter int unsigned ADDR_W  = 16,
    parameter int unsigned DEVT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              shutdown_i,
    input logic              wr_done_i,
    input logic              slot_rst_n_o,
    input logic              ctl_rst_n_o,
    input logic              slot_pwr_en_o,
    input logic              aux_clk_en_o,
    input logic              phy_hold_o,
    input logic              pwrup_rst_n_o,
    input logic [NUM_PHY-1:0] cfg_sel_o,
    input logic              wr_req_o,
    input logic [PHY_W-1:0]  wr_phy_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic [DEVT_W-1:0] dev_type_o,
    input logic              link_train_en_o,
    input logic              busy_o,
    input logic              err_o
);
    // R2
    pwr_under_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(slot_pwr_en_o) |-> (!slot_rst_n_o && !ctl_rst_n_o));

    // R4
    ctl_before_slot_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(slot_rst_n_o) |-> ctl_rst_n_o);

    // R5
    hold_with_clock_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(phy_hold_o) |-> aux_clk_en_o);

    // R7
    write_context_chk: assert property (@(posedge clk) disable iff (rst)
        wr_req_o |-> (phy_hold_o && pwrup_rst_n_o && (&cfg_sel_o) &&
                      aux_clk_en_o && !link_train_en_o));

    // R8
    req_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_req_o && !wr_done_i && !shutdown_i) |=>
            (wr_req_o && $stable(wr_addr_o) && $stable(wr_phy_o)));

    // R10
    link_en_context_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(link_train_en_o) |->
            ((dev_type_o == DEVT_W'(4)) && aux_clk_en_o && !phy_hold_o));

    // R10
    busy_link_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(busy_o && link_train_en_o));

    // R11
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        err_o |=> err_o);

    // R12
    shutdown_resets_chk: assert property (@(posedge clk) disable iff (rst)
        shutdown_i |=> (!slot_rst_n_o && !ctl_rst_n_o && !busy_o &&
                        !wr_req_o && !link_train_en_o));
endmodule

bind pcie_bringup_seq pbs_seq_chk #(
    .NUM_PHY (NUM_PHY),
    .PHY_W   (PHY_W),
    .ADDR_W  (ADDR_W),
    .DEVT_W  (DEVT_W)
) u_chk (
    .clk             (clk),
    .rst             (rst),
    .shutdown_i      (shutdown_i),
    .wr_done_i       (wr_done_i),
    .slot_rst_n_o    (slot_rst_n_o),
    .ctl_rst_n_o     (ctl_rst_n_o),
    .slot_pwr_en_o   (slot_pwr_en_o),
    .aux_clk_en_o    (aux_clk_en_o),
    .phy_hold_o      (phy_hold_o),
    .pwrup_rst_n_o   (pwrup_rst_n_o),
    .cfg_sel_o       (cfg_sel_o),
    .wr_req_o        (wr_req_o),
    .wr_phy_o        (wr_phy_o),
    .wr_addr_o       (wr_addr_o),
    .dev_type_o      (dev_type_o),
    .link_train_en_o (link_train_en_o),
    .busy_o          (busy_o),
    .err_o           (err_o)
);

// File: tb/sim_pcie_bringup_seq.sv
module sim_pcie_bringup_seq;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_PHY    = 2;
    localparam int LANES      = 4;
    localparam int PERST_MS   = 3;
    localparam int SEL_WAIT   = 5;
    localparam int TICK_DIV   = 4;
    localparam int NWR        = NUM_PHY * LANES;

    logic clk = 1'b0;
    logic rst, start_i, shutdown_i, ms_tick_i, wr_done_i, wr_err_i;
    logic slot_rst_n_o, ctl_rst_n_o, slot_pwr_en_o, aux_clk_en_o;
    logic phy_hold_o, pwrup_rst_n_o, wr_req_o, link_train_en_o, busy_o, err_o;
    logic [NUM_PHY-1:0] cfg_sel_o;
    logic [0:0]  wr_phy_o;
    logic [15:0] wr_addr_o, wr_data_o;
    logic [3:0]  dev_type_o;

    int checks = 0;
    int fails  = 0;
    logic exp_err = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pcie_bringup_seq #(
        .NUM_PHY(NUM_PHY), .LANES_PER_PHY(LANES), .PERST_MS(PERST_MS),
        .SEL_WAIT_CYC(SEL_WAIT), .ADDR_W(16), .DATA_W(16), .DEVT_W(4)
    ) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .shutdown_i(shutdown_i),
        .ms_tick_i(ms_tick_i), .wr_done_i(wr_done_i), .wr_err_i(wr_err_i),
        .slot_rst_n_o(slot_rst_n_o), .ctl_rst_n_o(ctl_rst_n_o),
        .slot_pwr_en_o(slot_pwr_en_o), .aux_clk_en_o(aux_clk_en_o),
        .phy_hold_o(phy_hold_o), .pwrup_rst_n_o(pwrup_rst_n_o),
        .cfg_sel_o(cfg_sel_o), .wr_req_o(wr_req_o), .wr_phy_o(wr_phy_o),
        .wr_addr_o(wr_addr_o), .wr_data_o(wr_data_o), .dev_type_o(dev_type_o),
        .link_train_en_o(link_train_en_o), .busy_o(busy_o), .err_o(err_o)
    );

    // millisecond tick, changed just after the rising edge
    initial begin
        ms_tick_i = 1'b0;
        forever begin
            repeat (TICK_DIV - 1) @(posedge clk);
            #1 ms_tick_i = 1'b1;
            @(posedge clk);
            #1 ms_tick_i = 1'b0;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; start_i = 1'b0; shutdown_i = 1'b0;
        wr_done_i = 1'b0; wr_err_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        exp_err = 1'b0;
        @(negedge clk);
        chk("R1 slot_rst_n", 32'(slot_rst_n_o), 0);
        chk("R1 ctl_rst_n", 32'(ctl_rst_n_o), 0);
        chk("R1 pwr_en", 32'(slot_pwr_en_o), 0);
        chk("R1 aux", 32'(aux_clk_en_o), 0);
        chk("R1 hold", 32'(phy_hold_o), 0);
        chk("R1 pwrup_rst_n", 32'(pwrup_rst_n_o), 0);
        chk("R1 cfg_sel", 32'(cfg_sel_o), 0);
        chk("R1 wr_req", 32'(wr_req_o), 0);
        chk("R1 dev_type", 32'(dev_type_o), 0);
        chk("R1 link_en", 32'(link_train_en_o), 0);
        chk("R1 busy", 32'(busy_o), 0);
        chk("R1 err", 32'(err_o), 0);
    endtask

    // Full walk; abort_at >= 0 issues a shutdown at that write instead of done
    task automatic run_seq(input bit from_up, input logic [7:0] err_mask,
                           input int abort_at, input bit poke_busy);
        int ticks;
        int gap;
        logic [15:0] addr_seen;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 slot reset low first", 32'(slot_rst_n_o), 0);
        chk("R2 busy on start", 32'(busy_o), 1);
        chk("R2 link off", 32'(link_train_en_o), 0);
        if (from_up) begin
            chk("R2 ctl still high on first cycle", 32'(ctl_rst_n_o), 1);
            chk("R2 aux cleared on restart", 32'(aux_clk_en_o), 0);
            chk("R2 dev_type cleared on restart", 32'(dev_type_o), 0);
        end
        @(negedge clk);
        chk("R2 ctl reset low", 32'(ctl_rst_n_o), 0);
        @(negedge clk);
        chk("R2 power on", 32'(slot_pwr_en_o), 1);
        ticks = 0;
        for (int i = 0; i < 1000 && !ctl_rst_n_o; i++) begin
            if (ms_tick_i) ticks++;
            @(negedge clk);
        end
        chk("R3 ticks during hold", 32'(ticks), 32'(PERST_MS + 1));
        chk("R4 slot still in reset", 32'(slot_rst_n_o), 0);
        @(negedge clk);
        chk("R4 slot released", 32'(slot_rst_n_o), 1);
        chk("R5 aux not yet", 32'(aux_clk_en_o), 0);
        @(negedge clk);
        chk("R5 aux on", 32'(aux_clk_en_o), 1);
        chk("R5 hold not yet", 32'(phy_hold_o), 0);
        @(negedge clk);
        chk("R5 hold on", 32'(phy_hold_o), 1);
        chk("R5 pwrup not yet", 32'(pwrup_rst_n_o), 0);
        @(negedge clk);
        chk("R5 pwrup released", 32'(pwrup_rst_n_o), 1);
        chk("R6 selects not yet", 32'(cfg_sel_o), 0);
        @(negedge clk);
        chk("R6 selects all set", 32'(cfg_sel_o), 32'((1 << NUM_PHY) - 1));
        gap = 0;
        while (!wr_req_o && gap < 100) begin
            @(negedge clk);
            gap++;
        end
        chk("R6 settle window met", 32'(gap >= SEL_WAIT), 1);
        for (int k = 0; k < NWR; k++) begin
            gap = 0;
            while (!wr_req_o && gap < 20) begin
                @(negedge clk);
                gap++;
            end
            chk("R7 request present", 32'(wr_req_o), 1);
            chk("R7 phy index", 32'(wr_phy_o), 32'(k / LANES));
            chk("R7 lane address", 32'(wr_addr_o), 32'(16'h1008 + 16'h0100 * (k % LANES)));
            chk("R7 lane data", 32'(wr_data_o), 32'h0E21);
            chk("R7 hold during write", 32'(phy_hold_o), 1);
            chk("R7 training off", 32'(link_train_en_o), 0);
            if (abort_at == k) begin
                shutdown_i = 1'b1;
                @(negedge clk);
                shutdown_i = 1'b0;
                chk("R12 slot reset", 32'(slot_rst_n_o), 0);
                chk("R12 ctl reset", 32'(ctl_rst_n_o), 0);
                chk("R12 req dropped", 32'(wr_req_o), 0);
                chk("R12 busy dropped", 32'(busy_o), 0);
                return;
            end
            addr_seen = wr_addr_o;
            for (int j = 0; j < 2; j++) begin
                if (poke_busy && k == 2 && j == 0) start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                chk("R8 request held", 32'(wr_req_o), 1);
                chk("R8 address stable", 32'(wr_addr_o), 32'(addr_seen));
                if (poke_busy && k == 2 && j == 0) begin
                    chk("R13 pwrup kept", 32'(pwrup_rst_n_o), 1);
                    chk("R13 hold kept", 32'(phy_hold_o), 1);
                    chk("R13 slot kept", 32'(slot_rst_n_o), 1);
                end
            end
            wr_done_i = 1'b1;
            wr_err_i  = err_mask[k];
            @(negedge clk);
            wr_done_i = 1'b0;
            wr_err_i  = 1'b0;
            if (err_mask[k]) exp_err = 1'b1;
            chk("R8 request dropped after done", 32'(wr_req_o), 0);
            chk("R11 error flag", 32'(err_o), 32'(exp_err));
        end
        chk("R9 aux still on after last done", 32'(aux_clk_en_o), 1);
        @(negedge clk);
        chk("R9 aux off", 32'(aux_clk_en_o), 0);
        chk("R9 hold still set", 32'(phy_hold_o), 1);
        @(negedge clk);
        chk("R9 hold cleared", 32'(phy_hold_o), 0);
        chk("R9 aux still off", 32'(aux_clk_en_o), 0);
        @(negedge clk);
        chk("R9 aux back on", 32'(aux_clk_en_o), 1);
        @(negedge clk);
        chk("R10 device type RC", 32'(dev_type_o), 4);
        chk("R10 training not yet", 32'(link_train_en_o), 0);
        chk("R10 busy before training", 32'(busy_o), 1);
        @(negedge clk);
        chk("R10 training on", 32'(link_train_en_o), 1);
        chk("R10 busy off", 32'(busy_o), 0);
        chk("R11 error after walk", 32'(err_o), 32'(exp_err));
    endtask

    task automatic shutdown_after_up();
        shutdown_i = 1'b1;
        @(negedge clk);
        shutdown_i = 1'b0;
        chk("R12 slot reset after up", 32'(slot_rst_n_o), 0);
        chk("R12 ctl reset after up", 32'(ctl_rst_n_o), 0);
        chk("R12 training off", 32'(link_train_en_o), 0);
        chk("R11 error still sticky", 32'(err_o), 32'(exp_err));
    endtask

    task automatic shutdown_in_wait();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        shutdown_i = 1'b1;
        start_i    = 1'b1;
        @(negedge clk);
        shutdown_i = 1'b0;
        start_i    = 1'b0;
        chk("R12 busy dropped in wait", 32'(busy_o), 0);
        chk("R12 ctl reset in wait", 32'(ctl_rst_n_o), 0);
        repeat (TICK_DIV * (PERST_MS + 3)) @(negedge clk);
        chk("R12 ctl never released", 32'(ctl_rst_n_o), 0);
        chk("R12 slot never released", 32'(slot_rst_n_o), 0);
        chk("R12 still idle", 32'(busy_o), 0);
    endtask

    initial begin
        do_reset();
        run_seq(1'b0, 8'h00, -1, 1'b0);
        run_seq(1'b1, 8'h08, -1, 1'b1);
        shutdown_after_up();
        do_reset();
        shutdown_in_wait();
        run_seq(1'b0, 8'h00, 5, 1'b0);
        run_seq(1'b0, 8'h00, -1, 1'b0);
        chk("R11 no error after clean walk", 32'(err_o), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule